// File: doc/BRIEF.md
# Free-running timer with prescaler

An up-counting 16-bit timer for general timing and for the capture and compare logic next to it. Each count tick adds one to the counter. A tick comes from one of two places: a prescaler that divides the peripheral clock by 4, 16, 32 or 64, or a rising edge on an external clock pin. The external pin is first brought into the peripheral clock domain through a synchronizer. The count value is driven out all the time. A compare-match clear request from neighbouring logic can return the counter to zero when that mode is enabled.

Software reaches the timer through a two-word register bus. Address 0 is an 8-bit control/status word. It holds the prescale code, the stop bit, a one-shot clear, the compare-clear enable, the source select, the overflow interrupt enable and the overflow flag. Address 1 is the count, which can be read and loaded. When the counter wraps it sets the overflow flag. The flag then raises an interrupt request if the enable is set.

Top module: `freerun_timer`

## Requirements
- R1: Control bits [1:0] pick the internal tick rate. Code 0 gives one tick every 4 clocks, code 1 every 16, code 2 every 32 and code 3 every 64. The prescaler runs freely from reset.
- R2: Control bit 4 halts counting while it is 1. While halted, neither prescaler ticks nor external edges change the count.
- R3: Control bit 7 = 1 takes ticks from the external pin. Each rising edge on the pin gives exactly one tick, two to three clocks later, and a pin held at one level gives none. Prescaler ticks are ignored in this mode.
- R4: Writing control bit 2 as 1 sets the count to zero on the next clock. Bit 2 always reads 0. Writing it as 0 leaves the count alone.
- R5: With control bit 3 = 1, a cmp_clear_req pulse sets the count to zero on the next clock, whether or not the timer is halted. With bit 3 = 0 the request has no effect.
- R6: A tick at count 0xFFFF gives 0x0000 and sets the overflow flag (control bit 6).
- R7: Writing control bit 6 as 0 clears the flag. Writing it as 1 leaves it unchanged, so software cannot set it. A wrap in the same clock as a software clear leaves the flag set.
- R8: irq is high exactly while both the overflow flag and the interrupt enable (control bit 5) are 1.
- R9: A write to address 1 loads wr_data into the count. A read at address 1 returns the count. A read at address 0 returns the control word in bits [7:0] with zeros above. The priority when several actions hit in one clock is: software clear, then load, then compare clear, then tick.
- R10: After reset the count is 0 and the control word reads 0x10. The timer is halted, the prescaler code is 0, the source is internal and the flag and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 control, 1 count |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| cmp_clear_req | input | 1 | Clear request from the compare-match logic |
| count_val | output | 16 | Current count |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions take the bus to be synchronous, with wr_en high for one clock per access. They take cmp_clear_req to be a clock-domain pulse. Only ext_clk_in may change freely. The bench drives every input at the falling edge and holds each external pin level for at least four clocks, so each edge passes the synchronizer cleanly. Tick-rate checks use windows that are whole multiples of the division ratio, so the result does not depend on the phase of the free-running prescaler.

// File: rtl/freerun_timer.sv
module freerun_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_clk_in,
  input  logic             cmp_clear_req,
  output logic [CNT_W-1:0] count_val,
  output logic             irq
);
  localparam int PRE_W = 6;

  logic [PRE_W-1:0] pre_q;
  logic [2:0]       ext_q;
  logic [CNT_W-1:0] cnt_q;
  logic             src_q, ovf_q, ie_q, stop_q, cmpen_q;
  logic [1:0]       div_q;
  logic             div_tick, ext_edge, tick;
  logic             ctrl_wr, cnt_wr, sw_clr, cmp_clr, wrap;
  logic [7:0]       ctrl_rd;

  always_comb begin
    case (div_q)
      2'd0:    div_tick = &pre_q[1:0];
      2'd1:    div_tick = &pre_q[3:0];
      2'd2:    div_tick = &pre_q[4:0];
      default: div_tick = &pre_q[5:0];
    endcase
  end

  assign ext_edge = ext_q[1] & ~ext_q[2];
  assign tick     = ~stop_q & (src_q ? ext_edge : div_tick);
  assign ctrl_wr  = wr_en & ~reg_addr;
  assign cnt_wr   = wr_en & reg_addr;
  assign sw_clr   = ctrl_wr & wr_data[2];
  assign cmp_clr  = cmp_clear_req & cmpen_q;
  assign wrap     = tick & (&cnt_q) & ~sw_clr & ~cnt_wr & ~cmp_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ext_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      ext_q <= {ext_q[1:0], ext_clk_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (sw_clr)  cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wr_data;
    else if (cmp_clr) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      ie_q    <= 1'b0;
      stop_q  <= 1'b1;
      cmpen_q <= 1'b0;
      div_q   <= 2'd0;
      ovf_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        src_q   <= wr_data[7];
        ie_q    <= wr_data[5];
        stop_q  <= wr_data[4];
        cmpen_q <= wr_data[3];
        div_q   <= wr_data[1:0];
      end
      ovf_q <= wrap | (ovf_q & ~(ctrl_wr & ~wr_data[6]));
    end
  end

  assign ctrl_rd   = {src_q, ovf_q, ie_q, stop_q, cmpen_q, 1'b0, div_q};
  assign rd_data   = reg_addr ? cnt_q : {{(CNT_W-8){1'b0}}, ctrl_rd};
  assign count_val = cnt_q;
  assign irq       = ovf_q & ie_q;
endmodule

module freerun_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_addr,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             cmp_clear_req,
  input logic [CNT_W-1:0] count_val,
  input logic             irq,
  input logic             stop,
  input logic             cmpen,
  input logic             ovf,
  input logic             ie
);
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en && !(cmp_clear_req && cmpen)) |=> $stable(count_val));

  a_r4_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_addr && wr_data[2]) |=> (count_val == '0));

  a_r5_cmp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clear_req && cmpen && !wr_en) |=> (count_val == '0));

  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count_val) && !wr_en && !(cmp_clear_req && cmpen))
      |=> ((&count_val) || (count_val == '0 && ovf)));

  a_r7_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !(&count_val)) |=> !ovf);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie || !ovf) |-> !irq);

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr) |=> (count_val == $past(wr_data)));
endmodule

bind freerun_timer freerun_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
  .wr_data(wr_data), .cmp_clear_req(cmp_clear_req), .count_val(count_val),
  .irq(irq), .stop(stop_q), .cmpen(cmpen_q), .ovf(ovf_q), .ie(ie_q)
);

// File: tb/freerun_timer_bench.sv
`timescale 1ns/1ps
module freerun_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_addr = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        ext_clk_in = 1'b0;
  logic        cmp_clear_req = 1'b0;
  logic [15:0] count_val;
  logic        irq;
  int checks = 0;
  int errors = 0;

  localparam int NV = 5;
  localparam int VDIV [NV] = '{0, 1, 2, 3, 0};
  localparam int VCYC [NV] = '{40, 64, 96, 128, 8};
  localparam int VEXP [NV] = '{10, 4, 3, 2, 2};

  always #10 clk = ~clk;

  freerun_timer u_freerun_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ext_clk_in(ext_clk_in),
    .cmp_clear_req(cmp_clear_req), .count_val(count_val), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic a, input logic [15:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a;
    #1 d = rd_data;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1'b1; repeat (4) @(negedge clk);
      ext_clk_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(1'b0, v); check("R10 ctrl reset", v, 16'h0010);
    rd(1'b1, v); check("R10 count reset", v, 16'h0000);
    check("R10 irq reset", {15'd0, irq}, 16'h0000);

    // R1: tick rate table, windows of N counted edges
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, 16'h0010);
      wr(1'b1, 16'h0000);
      wr(1'b0, 16'(VDIV[i]));
      repeat (VCYC[i] - 1) @(negedge clk);
      wr(1'b0, 16'h0010);
      rd(1'b1, v);
      check("R1 prescale rate", v, 16'(VEXP[i]));
    end

    // R2: halted timer keeps its value
    wr(1'b1, 16'h0042);
    repeat (80) @(negedge clk);
    rd(1'b1, v); check("R2 halt", v, 16'h0042);

    // R9: load and readback
    wr(1'b1, 16'h1234);
    rd(1'b1, v); check("R9 load", v, 16'h1234);
    check("R9 count port", count_val, 16'h1234);

    // R4: writing 0 to bit 2 leaves the count, writing 1 clears it
    wr(1'b0, 16'h0010);
    rd(1'b1, v); check("R4 zero no effect", v, 16'h1234);
    wr(1'b0, 16'h0014);
    rd(1'b1, v); check("R4 sw clear", v, 16'h0000);
    rd(1'b0, v); check("R4 bit2 reads 0", v, 16'h0010);

    // R5: compare clear gated by bit 3
    wr(1'b1, 16'h0055);
    cmp_clear_req = 1'b1; @(negedge clk); cmp_clear_req = 1'b0;
    rd(1'b1, v); check("R5 cmp disabled", v, 16'h0055);
    wr(1'b0, 16'h0018);
    cmp_clear_req = 1'b1; @(negedge clk); cmp_clear_req = 1'b0;
    rd(1'b1, v); check("R5 cmp enabled", v, 16'h0000);

    // R6 / R8: wrap from 0xFFFE with five ticks at divide-by-4
    wr(1'b0, 16'h0010);
    wr(1'b1, 16'hFFFE);
    wr(1'b0, 16'h0020);
    repeat (19) @(negedge clk);
    wr(1'b0, 16'h0070);
    rd(1'b1, v); check("R6 wrapped count", v, 16'h0003);
    rd(1'b0, v); check("R6 flag set", v, 16'h0070);
    check("R8 irq high", {15'd0, irq}, 16'h0001);

    // R7: writing 1 keeps the flag, writing 0 clears it
    wr(1'b0, 16'h0050);
    rd(1'b0, v); check("R7 write 1 keeps", v, 16'h0050);
    check("R8 irq masked", {15'd0, irq}, 16'h0000);
    wr(1'b0, 16'h0030);
    rd(1'b0, v); check("R7 write 0 clears", v, 16'h0030);
    check("R8 irq low", {15'd0, irq}, 16'h0000);
    wr(1'b0, 16'h0010);
    rd(1'b0, v); check("R7 no sw set", v & 16'h0040, 16'h0000);

    // R3: external edges
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0080);
    ext_pulses(5);
    repeat (4) @(negedge clk);
    rd(1'b1, v); check("R3 ext edges", v, 16'h0005);
    ext_clk_in = 1'b1;
    repeat (40) @(negedge clk);
    rd(1'b1, v); check("R3 level no tick", v, 16'h0006);
    ext_clk_in = 1'b0;
    repeat (40) @(negedge clk);
    rd(1'b1, v); check("R3 falling no tick", v, 16'h0006);

    // R2: external edges ignored while halted
    wr(1'b0, 16'h0090);
    ext_pulses(3);
    repeat (4) @(negedge clk);
    rd(1'b1, v); check("R2 halt ext", v, 16'h0006);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule